// File: doc/BRIEF.md
# Periodic Battery Health Check Sequencer

This block schedules a duty-cycled health check of a backup battery. It turns on a test load for a short window at a long, fixed repetition period. It samples a comparator flag that reports whether the loaded battery sits above its threshold. The result is kept in a registered battery-OK status bit. The comparator, its hysteresis and the divider load are outside the block. The block sees only a flag that has already been synchronised to its clock, and it drives only the strobe that enables the load.

The schedule is tied to the supervisor's reset. While that reset is asserted, the load stays off and the period count is cleared. Counting starts once the reset is released, so the first measurement finishes exactly one full period after release. Both the period and the load window are parameters counted in clock cycles. A 200 ms period and a 25 µs window therefore become cycle counts derived from the clock rate.

Top module: `batt_health_seq`

## Requirements
- R1: After the power-on reset (`rst_n` low), `batt_ok_o` reads 1 and `load_en_o` reads 0, and battery-OK stays 1 until the first measurement completes.
- R2: While `sup_rst_i` is 1, `load_en_o` is 0 in the same cycle, the period count is cleared and `batt_ok_o` is not changed.
- R3: Number the clock edges since the supervisor reset was released as k = 1, 2, … (the first edge with `sup_rst_i` low is k = 1). After edge k, `load_en_o` is 1 exactly when (k mod PERIOD) ≥ PERIOD − WINDOW. The window is therefore WINDOW consecutive cycles, it repeats every PERIOD cycles, and its first cycle falls PERIOD − WINDOW edges after release.
- R4: On each edge k that is a multiple of PERIOD (the last cycle of a load window), `batt_ok_o` takes the value that `batt_hi_i` has at that edge: 1 means the battery is above its threshold, 0 means it is below.
- R5: Values of `batt_hi_i` at any other edge, including the earlier cycles of the load window, leave `batt_ok_o` unchanged.
- R6: A measured result is held until the next measurement. A low result returns to 1 only when a later measurement finds the flag high.
- R7: A supervisor reset that arrives inside a load window aborts that measurement, so `batt_ok_o` is not updated. The schedule restarts from zero on release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one schedule tick |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sup_rst_i | input | 1 | Supervisor reset state, 1 = reset asserted |
| batt_hi_i | input | 1 | Synchronised comparator flag, 1 = battery above threshold |
| load_en_o | output | 1 | Test-load enable strobe |
| batt_ok_o | output | 1 | Registered battery-OK status |

## Verification
The bench builds the block with PERIOD = 8 and WINDOW = 3. With these values every position inside the period, every edge of the window and every sample edge comes up dozens of times within a few hundred cycles. The bench walks all sixteen four-bit result sequences in which the flag is held at the wanted value only on the sample edge and at its complement everywhere else. This exercises every high-to-low and low-to-high transition of the status and every ignored flag change. A supervisor reset placed inside a window, one cycle before the sample, shows that the measurement is aborted and that the schedule restarts in the right phase.

// File: rtl/bhc_pkg.sv
package bhc_pkg;
  // Width of a counter that must hold values 0 .. n-1.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bhc_period_ctr.sv
module bhc_period_ctr
  import bhc_pkg::*;
#(
  parameter int unsigned PERIOD = 8,
  localparam int unsigned CW = cnt_width(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  output logic [CW-1:0] pos,
  output logic          sample
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pos <= '0;
    else if (hold)       pos <= '0;
    else if (pos == LAST) pos <= '0;
    else                 pos <= pos + 1'b1;
  end

  // The edge that closes a period is the sampling edge.
  assign sample = !hold && (pos == LAST);

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST);  // R3
  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) |-> pos == '0);  // R2
endmodule

// File: rtl/bhc_window_dec.sv
module bhc_window_dec
  import bhc_pkg::*;
#(
  parameter int unsigned PERIOD = 8,
  parameter int unsigned WINDOW = 3,
  localparam int unsigned CW = cnt_width(PERIOD)
) (
  input  logic [CW-1:0] pos,
  input  logic          hold,
  output logic          load_en
);
  logic in_win;

  generate
    if (WINDOW >= PERIOD) begin : g_full
      assign in_win = 1'b1;
    end else begin : g_part
      localparam logic [CW-1:0] FIRST = CW'(PERIOD - WINDOW);
      assign in_win = (pos >= FIRST);
    end
  endgenerate

  assign load_en = in_win && !hold;
endmodule

// File: rtl/bhc_result_reg.sv
module bhc_result_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic flag,
  output logic ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ok <= 1'b1;
    else if (capture) ok <= flag;
  end

  AST_OK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(ok));  // R5
  AST_OK_TAKES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> ok == $past(flag));  // R4
endmodule

// File: rtl/batt_health_seq.sv
module batt_health_seq
  import bhc_pkg::*;
#(
  parameter int unsigned PERIOD = 8,
  parameter int unsigned WINDOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_rst_i,
  input  logic batt_hi_i,
  output logic load_en_o,
  output logic batt_ok_o
);
  localparam int unsigned CW = cnt_width(PERIOD);

  logic [CW-1:0] pos;
  logic          sample;

  bhc_period_ctr #(.PERIOD(PERIOD)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (sup_rst_i),
    .pos    (pos),
    .sample (sample)
  );

  bhc_window_dec #(.PERIOD(PERIOD), .WINDOW(WINDOW)) u_win (
    .pos     (pos),
    .hold    (sup_rst_i),
    .load_en (load_en_o)
  );

  bhc_result_reg u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (sample),
    .flag    (batt_hi_i),
    .ok      (batt_ok_o)
  );

  AST_SAMPLE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> load_en_o);  // R4
  AST_NO_SAMPLE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    sup_rst_i |=> $stable(batt_ok_o));  // R7

  generate
    if (WINDOW < PERIOD) begin : g_start_chk
      AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(load_en_o) && !$past(sup_rst_i)) |-> pos == CW'(PERIOD - WINDOW));  // R3
    end
  endgenerate
endmodule

// File: tb/batt_health_seq_tb.sv
module batt_health_seq_tb_top;
  localparam int P = 8;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_rst = 1'b1;
  logic batt_hi = 1'b0;
  logic load_en, batt_ok;

  int checks = 0;
  int errors = 0;
  int k = 0;
  logic exp_ok = 1'b1;
  logic chk_en = 1'b0;
  string ok_tag = "R1";

  always #2.5 clk = ~clk;

  batt_health_seq #(.PERIOD(P), .WINDOW(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sup_rst_i(sup_rst), .batt_hi_i(batt_hi),
    .load_en_o(load_en), .batt_ok_o(batt_ok)
  );

  // Arithmetic reference: edges since release and last sampled flag.
  always @(posedge clk) begin
    if (!rst_n) begin
      k = 0; exp_ok = 1'b1;
    end else if (sup_rst) begin
      k = 0;
    end else begin
      k = k + 1;
      if (k % P == 0) exp_ok = batt_hi;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b (k=%0d)", tag, act, exp, k);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      logic exp_load;
      exp_load = rst_n && !sup_rst && ((k % P) >= P - W);
      check(sup_rst ? "R2" : "R3", load_en, exp_load);
      check(ok_tag, batt_ok, exp_ok);
    end
  end

  // Drive the flag for the edge that follows: wanted value only on a sample edge.
  task automatic drive_for_next(input logic want);
    batt_hi = (((k + 1) % P) == 0) ? want : ~want;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: power-on state
    check("R1", batt_ok, 1'b1);
    check("R1", load_en, 1'b0);
    rst_n = 1'b1;
    chk_en = 1'b1;
    ok_tag = "R2";
    batt_hi = 1'b0;
    repeat (5) @(negedge clk);       // R2: held in supervisor reset
    sup_rst = 1'b0;
    ok_tag = "R1";
    // R1: flag low before the first sample must not drop battery-OK
    for (int c = 0; c < P - 1; c++) begin
      batt_hi = 1'b0;
      @(negedge clk);
    end
    // R4 R5 R6: all 4-bit result sequences, flag complemented off the sample edge
    ok_tag = "R4 R5 R6";
    batt_hi = 1'b1;                  // first sample edge: high
    @(negedge clk);
    for (int pat = 0; pat < 16; pat++) begin
      for (int b = 0; b < 4; b++) begin
        for (int c = 0; c < P; c++) begin
          drive_for_next(pat[b]);
          @(negedge clk);
        end
      end
    end
    // R7: reset one cycle before the sample edge, flag opposite of status
    ok_tag = "R7";
    while ((k % P) != P - 2) begin
      drive_for_next(1'b0);
      @(negedge clk);
    end
    batt_hi = 1'b1;
    @(negedge clk);                  // now at the last window cycle
    begin
      logic held;
      held = batt_ok;
      batt_hi = ~held;
      sup_rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R7", batt_ok, held);
      check("R2", load_en, 1'b0);
    end
    sup_rst = 1'b0;
    ok_tag = "R3 R7";
    for (int c = 0; c < 3 * P; c++) begin
      drive_for_next(c[4]);
      @(negedge clk);
    end
    chk_en = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule